// File: doc/BRIEF.md
# Charger Power Switch Controller

This block holds the digital control for the switch that connects an external charger to the battery node. It takes a set of comparator results from the analog front end: the charger is above its power-on-reset level, the output has reached the startup cutoff, the output has dropped below that cutoff by the hysteresis amount, and the output is above the low or the high overvoltage threshold. It also takes a limit-select level and the host's PWM charging line. From these it drives the enable of the startup trickle current, the main switch command and a soft-switch level code that the analog switch driver follows.

While the host holds PWM low, the block runs in startup mode. The trickle current flows until the output reaches the cutoff, and it starts again only once the output has sagged by the hysteresis amount. When the host drives PWM, the block measures the spacing of rising edges against a prescaled time base. A slow PWM gates the switch on and off with the PWM level. A fast PWM keeps the switch on whatever the duty cycle. An overvoltage on the selected limit cuts the switch off in the same cycle, with no ramp. The switch then stays off until the host drops PWM with the output back in range, or until the charger input collapses.

Top module: `chg_switch_ctrl`

## Requirements
- R1: startup_en_o is high only when chg_ok_i is high, pwm_i is low, the rate classifier is in slow mode and no selected overvoltage is present. Under those conditions, with no startup cutoff in force, it is high.
- R2: A startup cutoff starts in the cycle above_start_i is high, and startup_en_o drops in that same cycle. While the cutoff holds, startup_en_o stays low until below_hyst_i is high, and it rises combinationally in that cycle, which also clears the cutoff. If both flags are high in one cycle, the cutoff wins. After reset no cutoff is in force.
- R3: ovp_hi_sel_o is lim_sel_i registered by one clock and is 0 in and after reset. While it is 1, ov_hi_i is the overvoltage flag in use and ov_lo_i has no effect. While it is 0, ov_lo_i is in use.
- R4: In any cycle where the selected overvoltage flag is high, sw_on_o is 0, sw_level_o is 0 and startup_en_o is 0, all in that same cycle.
- R5: After an overvoltage event, the switch stays off while pwm_i stays high, even once the flag has cleared. A cycle with the flag low and pwm_i low releases the latch, and a later high PWM ramps the switch on again.
- R6: While chg_ok_i is low, sw_on_o, sw_level_o and startup_en_o are 0 in that same cycle and the overvoltage latch is released. When the charger returns with pwm_i high, the switch ramps on.
- R7: A rising PWM edge sets fast mode when fewer than FAST_TICKS full prescaler ticks (PRESC_DIV cycles each) have passed since the previous rising edge, and otherwise sets slow mode. For an edge spacing of P cycles the tick count is floor((P-1)/PRESC_DIV). The block is in slow mode after reset.
- R8: In slow mode the switch request follows the pwm_i level: on while high, off while low.
- R9: In fast mode the switch request stays on at any duty cycle, 0 % included. When 3*FAST_TICKS ticks pass without a rising edge, the block falls back to slow mode.
- R10: On a request change, sw_level_o moves one step toward its target every STEP_CYC cycles, to 2**LVL_W-1 when on and to 0 when off. sw_on_o is 1 exactly when sw_level_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_ok_i | input | 1 | Charger input above power-on-reset level |
| above_start_i | input | 1 | Output at or above startup cutoff |
| below_hyst_i | input | 1 | Output below cutoff minus hysteresis |
| ov_lo_i | input | 1 | Output above lower overvoltage limit |
| ov_hi_i | input | 1 | Output above higher overvoltage limit |
| lim_sel_i | input | 1 | Limit select, 1 = higher limit |
| pwm_i | input | 1 | Host charging PWM |
| ovp_hi_sel_o | output | 1 | Registered limit selection in use |
| startup_en_o | output | 1 | Startup trickle current enable |
| sw_on_o | output | 1 | Main switch command |
| sw_level_o | output | LVL_W | Soft-switch drive level |

## Verification
The comparator paths are combinational, so the cutoff, the release, the overvoltage kill and the charger-loss kill are sampled 1 time unit after the input is driven at a falling clock edge, before any rising edge. The limit selection appears after one rising edge. A ramp step lands STEP_CYC rising edges after the request changes, so a full ramp is checked 2**LVL_W-1 times STEP_CYC edges after the change. The rate class changes at the rising edge that samples the second PWM rise, and the bench places edges exactly 16 and 17 cycles apart to straddle the fast threshold. Between scenarios the bench idles long enough for the period counter to saturate, so no stray edge pair is classed as fast.

// File: rtl/chg_switch_pkg.sv
package chg_switch_pkg;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  typedef struct packed {
    logic chg_ok;
    logic above_start;
    logic below_hyst;
    logic ov_sel;
  } sense_t;

endpackage

// File: rtl/chg_rate_det.sv
module chg_rate_det #(
  parameter int PRESC_DIV  = 1000,
  parameter int FAST_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  output logic pwm_rise_o,
  output logic fast_o
);

  localparam int MISS_TICKS = 3 * FAST_TICKS;
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int CW = $clog2(MISS_TICKS + 1);

  logic          pwm_q;
  logic [PW-1:0] presc_q, presc_d;
  logic [CW-1:0] per_q, per_d;
  logic          fast_q, fast_d;
  logic          rise, tick;

  assign rise = pwm_i & ~pwm_q;
  assign tick = (presc_q == PW'(PRESC_DIV - 1));

  always_comb begin
    presc_d = presc_q;
    per_d   = per_q;
    fast_d  = fast_q;
    if (rise) begin
      presc_d = '0;
      per_d   = '0;
      fast_d  = (per_q < CW'(FAST_TICKS));
    end else if (tick) begin
      presc_d = '0;
      if (per_q != CW'(MISS_TICKS)) begin
        per_d = per_q + 1'b1;
        if (per_d == CW'(MISS_TICKS)) begin
          fast_d = 1'b0;
        end
      end
    end else begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      presc_q <= '0;
      per_q   <= CW'(MISS_TICKS);
      fast_q  <= 1'b0;
    end else begin
      pwm_q   <= pwm_i;
      presc_q <= presc_d;
      per_q   <= per_d;
      fast_q  <= fast_d;
    end
  end

  assign pwm_rise_o = rise;
  assign fast_o     = fast_q;

  AST_FAST_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_q) |-> $past(rise)); // R7

  AST_PERIOD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= CW'(MISS_TICKS)); // R9

endmodule

// File: rtl/chg_startup_ctl.sv
module chg_startup_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic clear_i,
  input  logic above_start_i,
  input  logic below_hyst_i,
  output logic en_o
);

  logic cutoff_q, cutoff_d;

  always_comb begin
    cutoff_d = cutoff_q;
    if (clear_i) begin
      cutoff_d = 1'b0;
    end else if (above_start_i) begin
      cutoff_d = 1'b1;
    end else if (below_hyst_i) begin
      cutoff_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cutoff_q <= 1'b0;
    end else begin
      cutoff_q <= cutoff_d;
    end
  end

  assign en_o = mode_i & ~above_start_i & (~cutoff_q | below_hyst_i);

  AST_CUTOFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (above_start_i && !clear_i) |=> (!en_o || below_hyst_i)); // R2

endmodule

// File: rtl/chg_ovp_latch.sv
module chg_ovp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_i,
  input  logic pwm_i,
  input  logic chg_ok_i,
  output logic prot_o
);

  logic prot_q, prot_d;

  always_comb begin
    prot_d = prot_q;
    if (!chg_ok_i) begin
      prot_d = 1'b0;
    end else if (ov_i) begin
      prot_d = 1'b1;
    end else if (!pwm_i) begin
      prot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
    end
  end

  assign prot_o = prot_q;

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && pwm_i && chg_ok_i) |=> prot_q); // R5

  AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_ok_i |=> !prot_q); // R6

endmodule

// File: rtl/chg_soft_ramp.sv
module chg_soft_ramp
  import chg_switch_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int STEP_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             kill_i,
  output logic [LVL_W-1:0] level_o,
  output logic             on_o
);

  localparam int RAMP_MAX = (1 << LVL_W) - 1;
  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [LVL_W-1:0] level_q, level_d;
  logic [SW-1:0]    cnt_q, cnt_d;
  ramp_dir_e        dir;
  logic             step_due;

  always_comb begin
    if (req_i && (level_q != LVL_W'(RAMP_MAX))) begin
      dir = RAMP_UP;
    end else if (!req_i && (level_q != '0)) begin
      dir = RAMP_DOWN;
    end else begin
      dir = RAMP_HOLD;
    end
  end

  assign step_due = (cnt_q == SW'(STEP_CYC - 1));

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (kill_i) begin
      level_d = '0;
    end else if (dir != RAMP_HOLD) begin
      if (step_due) begin
        level_d = (dir == RAMP_UP) ? level_q + 1'b1 : level_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = kill_i ? '0 : level_q;
  assign on_o    = |level_o;

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_i |=> ((level_q == $past(level_q)) ||
                 (level_q == $past(level_q) + 1'b1) ||
                 (level_q + 1'b1 == $past(level_q)))); // R10

endmodule

// File: rtl/chg_switch_ctrl.sv
module chg_switch_ctrl
  import chg_switch_pkg::*;
#(
  parameter int PRESC_DIV  = 1000,
  parameter int FAST_TICKS = 125,
  parameter int LVL_W      = 3,
  parameter int STEP_CYC   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_ok_i,
  input  logic             above_start_i,
  input  logic             below_hyst_i,
  input  logic             ov_lo_i,
  input  logic             ov_hi_i,
  input  logic             lim_sel_i,
  input  logic             pwm_i,
  output logic             ovp_hi_sel_o,
  output logic             startup_en_o,
  output logic             sw_on_o,
  output logic [LVL_W-1:0] sw_level_o
);

  sense_t sense;
  logic   hi_sel_q;
  logic   fast, pwm_rise, prot, st_en, st_mode, sw_req, kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sel_q <= 1'b0;
    end else begin
      hi_sel_q <= lim_sel_i;
    end
  end

  always_comb begin
    sense.chg_ok      = chg_ok_i;
    sense.above_start = above_start_i;
    sense.below_hyst  = below_hyst_i;
    sense.ov_sel      = hi_sel_q ? ov_hi_i : ov_lo_i;
  end

  chg_rate_det #(
    .PRESC_DIV  (PRESC_DIV),
    .FAST_TICKS (FAST_TICKS)
  ) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_i      (pwm_i),
    .pwm_rise_o (pwm_rise),
    .fast_o     (fast)
  );

  assign st_mode = sense.chg_ok & ~pwm_i & ~fast & ~sense.ov_sel;

  chg_startup_ctl u_start (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (st_mode),
    .clear_i       (~sense.chg_ok),
    .above_start_i (sense.above_start),
    .below_hyst_i  (sense.below_hyst),
    .en_o          (st_en)
  );

  chg_ovp_latch u_ovp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ov_i     (sense.ov_sel),
    .pwm_i    (pwm_i),
    .chg_ok_i (sense.chg_ok),
    .prot_o   (prot)
  );

  assign kill   = sense.ov_sel | ~sense.chg_ok;
  assign sw_req = sense.chg_ok & ~prot & ~sense.ov_sel & (fast | pwm_i);

  chg_soft_ramp #(
    .LVL_W    (LVL_W),
    .STEP_CYC (STEP_CYC)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (sw_req),
    .kill_i  (kill),
    .level_o (sw_level_o),
    .on_o    (sw_on_o)
  );

  assign ovp_hi_sel_o = hi_sel_q;
  assign startup_en_o = st_en;

  AST_OV_CUTS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((ov_lo_i && !ovp_hi_sel_o) || (ov_hi_i && ovp_hi_sel_o))
      |-> (!sw_on_o && sw_level_o == '0 && !startup_en_o)); // R4

  AST_STARTUP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    startup_en_o |-> (!pwm_i && chg_ok_i)); // R1

  AST_LIM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    lim_sel_i |=> ovp_hi_sel_o); // R3

  AST_NO_CHARGER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_ok_i |-> (!sw_on_o && !startup_en_o)); // R6

endmodule

// File: tb/chg_switch_ctrl_tb.sv
module chg_switch_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PD = 4;
  localparam int FT = 4;
  localparam int LW = 2;
  localparam int SC = 2;
  localparam int TOP = (1 << LW) - 1;

  logic clk, rst_n;
  logic chg_ok, above_start, below_hyst, ov_lo, ov_hi, lim_sel, pwm;
  logic hi_sel, st_en, sw_on;
  logic [LW-1:0] level;

  int n_chk, n_bad;
  bit done;

  chg_switch_ctrl #(
    .PRESC_DIV (PD), .FAST_TICKS (FT), .LVL_W (LW), .STEP_CYC (SC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .chg_ok_i (chg_ok),
    .above_start_i (above_start), .below_hyst_i (below_hyst),
    .ov_lo_i (ov_lo), .ov_hi_i (ov_hi), .lim_sel_i (lim_sel), .pwm_i (pwm),
    .ovp_hi_sel_o (hi_sel), .startup_en_o (st_en), .sw_on_o (sw_on),
    .sw_level_o (level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    bit cut_m;
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; chg_ok = 1'b1; above_start = 1'b0; below_hyst = 1'b0;
    ov_lo = 1'b0; ov_hi = 1'b0; lim_sel = 1'b1; pwm = 1'b0;
    wn(3);
    settle();
    chk("R10 reset sw_on", sw_on, 0);
    chk("R10 reset level", level, 0);
    chk("R3 reset hi_sel", hi_sel, 0);
    rst_n = 1'b1;
    wn(1);
    chk("R3 hi_sel after one edge", hi_sel, 1);
    lim_sel = 1'b0;
    wn(1);
    chk("R3 hi_sel back low", hi_sel, 0);

    // R1: startup mode with PWM low
    settle();
    chk("R1 startup enabled", st_en, 1);
    chg_ok = 1'b0; settle();
    chk("R1 startup off without charger", st_en, 0);
    wn(1); chg_ok = 1'b1; wn(1);

    // R2: sweep of cutoff / hysteresis flag patterns against a model
    cut_m = 1'b0;
    for (int i = 0; i < 16; i++) begin
      bit a, b;
      a = i[0];
      b = i[1] ^ i[2];
      above_start = a; below_hyst = b; settle();
      chk("R2 startup enable vs cutoff model", st_en, int'(!a && (!cut_m || b)));
      cut_m = a ? 1'b1 : (b ? 1'b0 : cut_m);
      wn(1);
    end
    above_start = 1'b1; below_hyst = 1'b0; wn(1);
    above_start = 1'b0; wn(3); settle();
    chk("R2 cutoff holds without hysteresis", st_en, 0);
    below_hyst = 1'b1; settle();
    chk("R2 hysteresis re-enables", st_en, 1);
    wn(1); below_hyst = 1'b0; settle();
    chk("R2 cutoff cleared", st_en, 1);
    wn(60);

    // R8: slow PWM gating with R10 ramp
    pwm = 1'b1; settle();
    chk("R1 startup off while PWM high", st_en, 0);
    wn(SC);
    chk("R10 first ramp step", level, 1);
    wn(SC * (TOP - 1));
    chk("R10 ramp reaches top", level, TOP);
    chk("R8 switch on with PWM high", sw_on, 1);
    pwm = 1'b0;
    wn(SC);
    chk("R10 first ramp down step", level, TOP - 1);
    wn(SC * (TOP - 1));
    chk("R8 switch off with PWM low", sw_on, 0);
    wn(60);

    // R4 / R5: overvoltage kill and latch
    pwm = 1'b1; wn(8);
    chk("R5 switch on before event", level, TOP);
    ov_lo = 1'b1; settle();
    chk("R4 instant switch off", sw_on, 0);
    chk("R4 instant level zero", level, 0);
    chk("R4 startup off", st_en, 0);
    wn(1); ov_lo = 1'b0; wn(12);
    chk("R5 latched while PWM high", sw_on, 0);
    pwm = 1'b0; wn(2);
    pwm = 1'b1; wn(SC * TOP + 1);
    chk("R5 restart after PWM low", level, TOP);

    // R3: limit selection
    lim_sel = 1'b1; wn(1);
    chk("R3 high limit selected", hi_sel, 1);
    ov_lo = 1'b1; wn(2);
    chk("R3 low flag ignored", level, TOP);
    ov_hi = 1'b1; settle();
    chk("R3 high flag cuts", sw_on, 0);
    wn(1); ov_hi = 1'b0; ov_lo = 1'b0; pwm = 1'b0; wn(1);
    lim_sel = 1'b0; wn(1);
    chk("R3 low limit again", hi_sel, 0);
    wn(60);

    // R6: charger loss
    pwm = 1'b1; wn(SC * TOP + 1);
    chk("R6 on before loss", level, TOP);
    chg_ok = 1'b0; settle();
    chk("R6 switch off on charger loss", sw_on, 0);
    chk("R6 startup off on charger loss", st_en, 0);
    wn(2); chg_ok = 1'b1; wn(SC * TOP + 1);
    chk("R6 ramps on after recovery", level, TOP);
    ov_lo = 1'b1; wn(1); ov_lo = 1'b0; wn(3);
    chk("R5 latch before charger loss", sw_on, 0);
    chg_ok = 1'b0; wn(2); chg_ok = 1'b1; wn(SC * TOP + 1);
    chk("R6 latch released by charger loss", level, TOP);
    pwm = 1'b0; wn(60);

    // R9: fast PWM holds the switch on
    for (int p = 0; p < 6; p++) begin
      pwm = 1'b1; wn(4); pwm = 1'b0; wn(4);
    end
    chk("R9 fast 50 percent holds on", level, TOP);
    chk("R1 no startup in fast mode", st_en, 0);
    for (int p = 0; p < 4; p++) begin
      pwm = 1'b1; wn(1); pwm = 1'b0; wn(7);
    end
    chk("R9 fast low duty holds on", level, TOP);
    wn(20);
    chk("R9 zero duty still on", sw_on, 1);
    wn(60);
    chk("R9 fallback to slow turns off", sw_on, 0);

    // R7: period threshold boundary (17 cycles slow, 16 fast)
    pwm = 1'b1; wn(1); pwm = 1'b0; wn(16);
    pwm = 1'b1; wn(1); pwm = 1'b0; wn(10);
    chk("R7 17 cycle period is slow", level, 0);
    wn(60);
    pwm = 1'b1; wn(1); pwm = 1'b0; wn(15);
    pwm = 1'b1; wn(1); pwm = 1'b0; wn(10);
    chk("R7 16 cycle period is fast", level, TOP);
    pwm = 1'b0; wn(80);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule